// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

This block takes signed left and right audio samples of up to 18 bits and sends them out one bit at a time on a single data line. The bits are framed by a bit clock and a word-select line. The block runs on a system clock at 256 times the sample rate. It has two roles. As clock master it divides the system clock down to make the bit clock and the word select itself. As clock follower it takes both lines from outside and times its data to them. Three output-enable signals let a pad ring tri-state the data, bit-clock and word-select pins.

Software or an upstream filter writes a new sample pair into two holding registers. A channel picks up its new sample only at the next word-select edge that starts that channel, so a word already on the line is never torn. Two select inputs choose the format. In master role there are two formats: a left-justified one, and an I2S-like one that puts the MSB one bit period after the word-select edge. In follower role the second select input chooses the delayed timing and also inverts the word-select polarity. A standby input turns off all three enables and restarts the timing when it is released.

Top module: `stereo_ser_tx`

## Requirements
- R1: When reset is released with standby off and master role selected, all three enables are high and the data, bit-clock and word-select outputs are low.
- R2: While standby is high, all three enables are low in either role. When standby is released in master role, the timing restarts at the first bit period of the left channel.
- R3: In master role the bit clock has a period of BCLK_DIV (default 4) system clocks, high for half of it.
- R4: In master role the word select is low for CH_SLOTS (default 32) bit periods, which carry the left channel, and then high for CH_SLOTS bit periods, which carry the right channel. It changes only when the bit clock falls.
- R5: In the left-justified timing, the MSB is on the line in the first bit period after a word-select edge.
- R6: In the delayed timing, the first bit period after a word-select edge carries 0 and the MSB follows in the second.
- R7: In master role, fmt_a_i high selects the left-justified timing and low selects the delayed timing. fmt_b_i changes neither the timing nor the word-select polarity.
- R8: In follower role, the bit-clock and word-select enables are low and the data enable is high. The data steps on each falling edge of the external bit clock.
- R9: In follower role, fmt_b_i low gives the left-justified timing, with word select low meaning left. fmt_b_i high gives the delayed timing, with word select high meaning left.
- R10: In follower role, fmt_a_i has no effect on the data output.
- R11: Each channel sends DATA_W (default 18) bits of the two's-complement sample, MSB first. All later bit periods of that channel carry 0.
- R12: A pulse on pcm_we_i updates both holding registers. A channel sends the new value only from its next word-select edge on, and a word already being sent keeps its old value.
- R13: In master role the data output changes only when the bit clock falls, and it stays stable while the bit clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 256 times the sample rate |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_i | input | 1 | Standby: 1 disables all outputs and clears timing |
| follower_i | input | 1 | Role: 1 means follower (external clocks), 0 means master |
| fmt_a_i | input | 1 | Primary format select |
| fmt_b_i | input | 1 | Secondary format select (timing and polarity in follower role) |
| pcm_we_i | input | 1 | Write strobe for the holding registers |
| pcm_l_i | input | DATA_W | Left sample, two's complement |
| pcm_r_i | input | DATA_W | Right sample, two's complement |
| bclk_i | input | 1 | External bit clock (follower role) |
| wsel_i | input | 1 | External word select (follower role) |
| txd_o | output | 1 | Serial data |
| txd_oe | output | 1 | Enable for the serial data pin |
| bclk_o | output | 1 | Generated bit clock (master role) |
| bclk_oe | output | 1 | Enable for the bit-clock pin |
| wsel_o | output | 1 | Generated word select (master role) |
| wsel_oe | output | 1 | Enable for the word-select pin |

## Verification
The bench decodes each channel from bits it samples on the rising bit-clock edge. It goes after the off-by-one between the two timings: a design that got this wrong would send a shifted word, or would leave a stray bit in the gap slot. Extreme samples (most negative, most positive, zero, all ones, alternating) expose a reversed bit order or a sign bit that gets lost. In follower role all four select combinations are run. An inverted polarity shows up as the right sample arriving in the left half. A sample written in the middle of a word must show up only on the next edge of each channel, so a design that loads on write, or loads both channels at once, gives a torn or early word.

// File: rtl/stx_pkg.sv
// Shared types and decode for the stereo serial transmitter.
// Assumes: one-bit role and format selects that are static while awake.
package stx_pkg;

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

    // Timing variant selected by the role and the two format inputs
    typedef struct packed {
        logic late;    // MSB one bit period after the word-select edge
        logic ws_inv;  // word select high means left
    } fmt_cfg_t;

    // Map role and selects to timing and polarity
    function automatic fmt_cfg_t decode_fmt(input logic follower,
                                            input logic fa,
                                            input logic fb);
        fmt_cfg_t c;
        if (follower) begin
            c.late   = fb;
            c.ws_inv = fb;
        end else begin
            c.late   = ~fa;
            c.ws_inv = 1'b0;
        end
        return c;
    endfunction

endpackage

// File: rtl/stx_bclk_gen.sv
// Master timing: divides the system clock into the bit clock and the word select.
// Assumes BCLK_DIV is a power of two of at least 2. A frame has 2*CH_SLOTS bit periods.
// fall_o marks the cycle whose next edge makes the bit clock fall.
module stx_bclk_gen #(
    parameter int BCLK_DIV = 4,
    parameter int CH_SLOTS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic bclk_o,
    output logic ws_o,
    output logic fall_o,
    output logic ws_next_o
);
    localparam int SUB_W = $clog2(BCLK_DIV);
    localparam int CNT_W = $clog2(2 * CH_SLOTS * BCLK_DIV);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;

    assign cnt_nxt = cnt_q + CNT_W'(1);

    // Free-running frame position counter, held at zero while cleared
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt_q <= '0;
        else               cnt_q <= cnt_nxt;
    end

    assign bclk_o    = cnt_q[SUB_W-1];
    assign ws_o      = cnt_q[CNT_W-1];
    assign fall_o    = &cnt_q[SUB_W-1:0];
    assign ws_next_o = cnt_nxt[CNT_W-1];

    // R3
    bclk_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !bclk_o);

endmodule

// File: rtl/stx_edge_sync.sv
// Follower timing: synchronizes the external bit clock and word select and flags
// each falling bit-clock edge. Both lines get the same delay, so the word select
// read with a fall is the one the external master set with that edge.
// Assumes the external bit clock stays high and low for several system clocks each.
module stx_edge_sync #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic bclk_i,
    input  logic ws_i,
    output logic fall_o,
    output logic ws_o
);
    logic [SYNC_N:0]   bclk_sh;
    logic [SYNC_N-1:0] ws_sh;

    // Synchronizer chains; the bit clock has one extra stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            bclk_sh <= '0;
            ws_sh   <= '0;
        end else begin
            bclk_sh[0] <= bclk_i;
            ws_sh[0]   <= ws_i;
            for (int i = 1; i <= SYNC_N; i++) bclk_sh[i] <= bclk_sh[i-1];
            for (int i = 1; i < SYNC_N; i++)  ws_sh[i]   <= ws_sh[i-1];
        end
    end

    assign fall_o = bclk_sh[SYNC_N] & ~bclk_sh[SYNC_N-1];
    assign ws_o   = ws_sh[SYNC_N-1];

    // R8
    fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);

endmodule

// File: rtl/stx_slot_engine.sv
// Serializer: two holding registers and a shift register. On a bit-clock fall event
// where the word select now names a different channel, it loads that channel's
// held sample. In late timing it sends one zero bit first. Zeros shift in behind
// the word, so every bit after the last data bit is 0.
module stx_slot_engine #(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              pcm_we,
    input  logic [DATA_W-1:0] pcm_l,
    input  logic [DATA_W-1:0] pcm_r,
    input  logic              evt,
    input  logic              ws_lvl,
    input  logic              ws_inv,
    input  logic              late,
    output logic              bit_o
);
    import stx_pkg::*;

    logic [DATA_W-1:0] hold_l, hold_r;
    logic [DATA_W-1:0] sh_q;
    logic [DATA_W-1:0] load_w;
    logic              bit_q;
    chan_e             ch_q;
    chan_e             ch_new;
    logic              edge_w;

    // Channel named by the word select, and whether this event starts it
    always_comb begin
        ch_new = chan_e'(ws_lvl ^ ws_inv);
        edge_w = evt && (ch_new != ch_q);
        load_w = (ch_new == CH_RIGHT) ? hold_r : hold_l;
    end

    // Holding registers written as a pair
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_l <= '0;
            hold_r <= '0;
        end else if (pcm_we) begin
            hold_l <= pcm_l;
            hold_r <= pcm_r;
        end
    end

    // Shift one bit per fall event; reload at a channel edge
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ch_q  <= CH_LEFT;
            sh_q  <= '0;
            bit_q <= 1'b0;
        end else if (edge_w) begin
            ch_q <= ch_new;
            if (late) begin
                bit_q <= 1'b0;
                sh_q  <= load_w;
            end else begin
                bit_q <= load_w[DATA_W-1];
                sh_q  <= {load_w[DATA_W-2:0], 1'b0};
            end
        end else if (evt) begin
            bit_q <= sh_q[DATA_W-1];
            sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
        end
    end

    assign bit_o = bit_q;

    // R5
    load_msb_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (edge_w && !late) |=> (bit_q == $past(load_w[DATA_W-1])));

    // R6
    late_gap_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (edge_w && late) |=> !bit_q);

    // R13
    bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
        !evt |=> $stable(bit_q));

endmodule

// File: rtl/stereo_ser_tx.sv
// Stereo serial audio transmitter top. Chooses master timing (generated) or
// follower timing (synchronized external lines) by role, drives the serializer,
// and makes the pin enables. Assumes the role and format selects change only in standby.
module stereo_ser_tx #(
    parameter int DATA_W   = 18,
    parameter int BCLK_DIV = 4,
    parameter int CH_SLOTS = 32,
    parameter int SYNC_N   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_i,
    input  logic              follower_i,
    input  logic              fmt_a_i,
    input  logic              fmt_b_i,
    input  logic              pcm_we_i,
    input  logic [DATA_W-1:0] pcm_l_i,
    input  logic [DATA_W-1:0] pcm_r_i,
    input  logic              bclk_i,
    input  logic              wsel_i,
    output logic              txd_o,
    output logic              txd_oe,
    output logic              bclk_o,
    output logic              bclk_oe,
    output logic              wsel_o,
    output logic              wsel_oe
);
    import stx_pkg::*;

    fmt_cfg_t cfg;
    logic gen_bclk, gen_ws, gen_fall, gen_ws_next;
    logic syn_fall, syn_ws;
    logic evt, ws_lvl;

    assign cfg = decode_fmt(follower_i, fmt_a_i, fmt_b_i);

    stx_bclk_gen #(.BCLK_DIV(BCLK_DIV), .CH_SLOTS(CH_SLOTS)) u_gen (
        .clk(clk), .rst_n(rst_n), .clr(sleep_i | follower_i),
        .bclk_o(gen_bclk), .ws_o(gen_ws), .fall_o(gen_fall), .ws_next_o(gen_ws_next)
    );

    stx_edge_sync #(.SYNC_N(SYNC_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .clr(sleep_i | ~follower_i),
        .bclk_i(bclk_i), .ws_i(wsel_i), .fall_o(syn_fall), .ws_o(syn_ws)
    );

    // Pick the timing source by role
    always_comb begin
        evt    = follower_i ? syn_fall : gen_fall;
        ws_lvl = follower_i ? syn_ws   : gen_ws_next;
    end

    stx_slot_engine #(.DATA_W(DATA_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .clr(sleep_i),
        .pcm_we(pcm_we_i), .pcm_l(pcm_l_i), .pcm_r(pcm_r_i),
        .evt(evt), .ws_lvl(ws_lvl), .ws_inv(cfg.ws_inv), .late(cfg.late),
        .bit_o(txd_o)
    );

    // Pin values and enables
    always_comb begin
        bclk_o  = follower_i ? 1'b0 : gen_bclk;
        wsel_o  = follower_i ? 1'b0 : gen_ws;
        txd_oe  = ~sleep_i;
        bclk_oe = ~sleep_i & ~follower_i;
        wsel_oe = ~sleep_i & ~follower_i;
    end

    // R13
    txd_on_fall_chk: assert property (@(posedge clk)
        disable iff (!rst_n || sleep_i || follower_i)
        !$stable(txd_o) |-> $fell(bclk_o));

    // R4
    ws_on_fall_chk: assert property (@(posedge clk)
        disable iff (!rst_n || sleep_i || follower_i)
        !$stable(wsel_o) |-> $fell(bclk_o));

endmodule

// File: tb/sim_stereo_ser_tx.sv
`timescale 1ns/1ps
module sim_stereo_ser_tx;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_i = 1'b0, follower_i = 1'b0, fmt_a_i = 1'b1, fmt_b_i = 1'b0;
    logic pcm_we_i = 1'b0;
    logic [17:0] pcm_l_i = '0, pcm_r_i = '0;
    logic bclk_i = 1'b1, wsel_i = 1'b0;
    logic txd_o, txd_oe, bclk_o, bclk_oe, wsel_o, wsel_oe;

    int n_chk = 0;
    int n_err = 0;
    logic cap_d [0:255];
    logic cap_w [0:255];

    always #2.5 clk = ~clk;

    stereo_ser_tx u0 (
        .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .follower_i(follower_i),
        .fmt_a_i(fmt_a_i), .fmt_b_i(fmt_b_i), .pcm_we_i(pcm_we_i),
        .pcm_l_i(pcm_l_i), .pcm_r_i(pcm_r_i), .bclk_i(bclk_i), .wsel_i(wsel_i),
        .txd_o(txd_o), .txd_oe(txd_oe), .bclk_o(bclk_o), .bclk_oe(bclk_oe),
        .wsel_o(wsel_o), .wsel_oe(wsel_oe)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Enter standby, set role/format, write samples, check enables off, then wake
    task automatic configure(input logic fol, input logic fa, input logic fb,
                             input logic [17:0] l, input logic [17:0] r);
        @(negedge clk);
        sleep_i = 1'b1; follower_i = fol; fmt_a_i = fa; fmt_b_i = fb;
        bclk_i = 1'b1; wsel_i = 1'b0;
        pcm_l_i = l; pcm_r_i = r; pcm_we_i = 1'b1;
        @(negedge clk);
        pcm_we_i = 1'b0;
        repeat (2) @(negedge clk);
        // R2: all enables off during standby
        chk({txd_oe, bclk_oe, wsel_oe} == 3'b000, "R2", {txd_oe, bclk_oe, wsel_oe}, 0);
        sleep_i = 1'b0;
    endtask

    // Capture master-role bits at each rising bit clock; optional mid-run write
    task automatic cap_master(input int nsl, input int wr_at, input logic [17:0] nl, input logic [17:0] nr);
        int k = 0;
        int since = 0;
        int bad_per = 0;
        int bad_hold = 0;
        logic pb = 1'b0;
        logic pt = 1'b0;
        while (k < nsl) begin
            @(negedge clk);
            pcm_we_i = 1'b0;
            since++;
            if (bclk_o && !pb) begin
                if (k > 0 && since != 4) bad_per++;
                cap_d[k] = txd_o;
                cap_w[k] = wsel_o;
                if (k == wr_at) begin
                    pcm_l_i = nl; pcm_r_i = nr; pcm_we_i = 1'b1;
                end
                k++;
                since = 0;
            end else if (bclk_o && pb && txd_o != pt) begin
                bad_hold++;
            end
            pb = bclk_o;
            pt = txd_o;
        end
        @(negedge clk);
        pcm_we_i = 1'b0;
        chk(bad_per == 0, "R3", bad_per, 0);
        chk(bad_hold == 0, "R13", bad_hold, 0);
    endtask

    // Drive external clock and word select; sample data just before each rise
    task automatic cap_slave(input int nfr, input logic inv);
        repeat (4) @(negedge clk);
        for (int j = 0; j < nfr * 64; j++) begin
            @(negedge clk);
            bclk_i = 1'b0;
            wsel_i = ((j % 64) >= 32) ^ inv;
            repeat (7) @(negedge clk);
            cap_d[j] = txd_o;
            cap_w[j] = wsel_i;
            @(negedge clk);
            bclk_i = 1'b1;
            repeat (6) @(negedge clk);
        end
    endtask

    // Decode one channel (32 bit periods from base) and compare, with zero tail
    task automatic chk_chan(input int base, input int d, input logic [17:0] exp, input string rq);
        logic [17:0] w = '0;
        int nz = 0;
        for (int i = 0; i < 18; i++) w = {w[16:0], cap_d[base + d + i]};
        for (int s = d + 18; s < 32; s++) if (cap_d[base + s]) nz++;
        if (d == 1 && cap_d[base]) nz++;
        chk(w == exp, rq, 32'(w), 32'(exp));
        chk(nz == 0, "R11", nz, 0);
    endtask

    task automatic master_run(input logic fa, input logic fb, input logic [17:0] l, input logic [17:0] r,
                              input logic [17:0] nl, input logic [17:0] nr);
        int d = fa ? 0 : 1;
        string rq = fa ? "R5" : "R6";
        int bad_ws = 0;
        if (fb) rq = "R7";
        configure(1'b0, fa, fb, l, r);
        cap_master(224, 130, nl, nr);
        chk_chan(64, d, l, rq);
        chk_chan(96, d, r, rq);
        // R12: write at bit period 130 leaves that left word, reaches right at 160, left at 192
        chk_chan(128, d, l, "R12");
        chk_chan(160, d, nr, "R12");
        chk_chan(192, d, nl, "R12");
        for (int i = 0; i < 32; i++) begin
            if (cap_w[64 + i] != 1'b0) bad_ws++;
            if (cap_w[96 + i] != 1'b1) bad_ws++;
        end
        // R4 (and R7: no polarity change from fmt_b in master role)
        chk(bad_ws == 0, fb ? "R7" : "R4", bad_ws, 0);
    endtask

    task automatic slave_run(input logic fa, input logic fb, input logic [17:0] l, input logic [17:0] r);
        string rq = fb ? "R9" : "R8";
        if (!fa) rq = "R10";
        configure(1'b1, fa, fb, l, r);
        @(negedge clk);
        // R8: follower role drives only data
        chk({txd_oe, bclk_oe, wsel_oe} == 3'b100, "R8", {txd_oe, bclk_oe, wsel_oe}, 3'b100);
        cap_slave(2, fb);
        chk_chan(64, fb ? 1 : 0, l, rq);
        chk_chan(96, fb ? 1 : 0, r, rq);
    endtask

    initial begin
        #750000;
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd5417);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: state just after reset in master role
        chk({txd_oe, bclk_oe, wsel_oe} == 3'b111, "R1", {txd_oe, bclk_oe, wsel_oe}, 3'b111);
        chk({txd_o, bclk_o, wsel_o} == 3'b000, "R1", {txd_o, bclk_o, wsel_o}, 0);

        // Directed corner samples (R11: sign and MSB order)
        master_run(1'b1, 1'b0, 18'h20000, 18'h1FFFF, 18'h00000, 18'h3FFFF);
        master_run(1'b0, 1'b0, 18'h2AAAA, 18'h15555, 18'h00001, 18'h20000);
        master_run(1'b0, 1'b1, 18'h3FFFF, 18'h00000, 18'h12345, 18'h2BCDE);
        master_run(1'b1, 1'b1, 18'h00001, 18'h20001, 18'h3FFFE, 18'h1FFFF);
        slave_run(1'b1, 1'b0, 18'h20000, 18'h1FFFF);
        slave_run(1'b1, 1'b1, 18'h2AAAA, 18'h15555);
        slave_run(1'b0, 1'b0, 18'h3FFFF, 18'h00001);
        slave_run(1'b0, 1'b1, 18'h00001, 18'h3FFFE);

        // Random samples and formats
        for (int t = 0; t < 4; t++) begin
            master_run(1'($urandom), 1'($urandom), 18'($urandom), 18'($urandom),
                       18'($urandom), 18'($urandom));
            slave_run(1'($urandom), 1'($urandom), 18'($urandom), 18'($urandom));
        end

        // R2: back to master role after standby starts at the left channel
        configure(1'b0, 1'b1, 1'b0, 18'h0F0F0, 18'h30303);
        @(negedge clk);
        chk(wsel_o == 1'b0 && bclk_o == 1'b0, "R2", {wsel_o, bclk_o}, 0);

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule